// File: doc/BRIEF.md
# Write-Through Word Cache

This block is a direct-mapped data cache placed between a processor port and a main-memory port. Both ports use 22-bit byte addresses and 16-bit words. Each of the 4096 lines holds one word, a 9-bit tag, three even-parity bits and one valid bit in each of two valid banks. Read hits finish in the request cycle. Read misses fetch the word from memory and fill the line. Every store is written through to memory. Accesses to the uncached I/O region pass straight through.

A whole-cache clear takes one cycle: the active valid bank is swapped for the other bank, which is already clear. A background walker then clears the bank that was just abandoned. A lookup with bad parity counts as a miss. The word is fetched again and rewritten, and the error is recorded. A fault-injection input lets tests plant a bad parity bit on purpose.

Top module: `wt_word_cache`

## Requirements
- R1: A line is selected by address bits 12:1, and its tag is address bits 21:13. A read whose line is valid in the active bank, whose tag matches and whose parity is good raises `cpu_ack` in the same cycle as `cpu_req`, returns the stored word, and makes no memory request.
- R2: On a cacheable read miss, the block holds `mem_req` with the CPU address stable until `mem_ack`. It raises `cpu_ack` with `mem_rdata` in that same cycle and fills the line, so the next read of that word hits.
- R3: Every store, hit or miss, produces exactly one memory write carrying the CPU address, byte enables and data. `cpu_ack` follows `mem_ack`.
- R4: On a store hit, only the enabled bytes of the line are updated (`be[0]` covers bits 7:0 and `be[1]` covers bits 15:8). A store miss does not allocate a line.
- R5: Two addresses with the same index and different tags evict each other.
- R6: Addresses whose bits 21:18 are all ones are never cached. Every access to them goes to memory.
- R7: A one-cycle `inv_req` while `inv_busy` is low makes every line miss from the next access onward. `inv_busy` then stays high for exactly 4096 cycles while the old bank is cleared.
- R8: `inv_req` while `inv_busy` is high is ignored, so lines filled since the last clear still hit.
- R9: During and after reset, `cpu_ack`, `mem_req` and `par_err` are low and `inv_busy` is high while both banks are cleared. Accesses made in that window go to memory and do not allocate.
- R10: Parity is even over each data byte and over the tag. A fill made with `fault_inj` high inverts the low-byte parity bit. A lookup with a parity mismatch is a miss: the word is refetched and rewritten, `par_err` is set and stays set, and `err_addr` takes the access address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | CPU access request, held until `cpu_ack` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_be | input | 2 | Byte enables for a store |
| cpu_addr | input | 22 | CPU byte address |
| cpu_wdata | input | 16 | Store data |
| cpu_ack | output | 1 | Access complete |
| cpu_rdata | output | 16 | Load data, valid with `cpu_ack` |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | Memory write |
| mem_be | output | 2 | Memory byte enables |
| mem_addr | output | 22 | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_ack | input | 1 | Memory completion pulse |
| mem_rdata | input | 16 | Memory read data, valid with `mem_ack` |
| inv_req | input | 1 | Whole-cache clear request |
| inv_busy | output | 1 | Background clear in progress |
| fault_inj | input | 1 | Plant a bad low-byte parity bit on fills |
| par_err | output | 1 | Sticky parity-error flag |
| err_addr | output | 22 | Address of the last parity failure |

## Verification
A read-miss fill of the active bank and a step of the background clear of the inactive bank can land in the same cycle, even on the same index. The bench provokes this by issuing a clear and then reading a miss while `inv_busy` is still high. It judges the result by requiring that the next read of that word makes no memory request and that `inv_busy` still lasts exactly 4096 cycles. A refused second clear is issued inside the same window, and the filled line must still hit afterwards.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
    localparam int ADDR_W = 22;
    localparam int WORD_W = 16;
    localparam int IDX_W  = 12;
    localparam int TAG_W  = ADDR_W - IDX_W - 1;
    localparam int LINES  = 1 << IDX_W;
    localparam int IO_W   = 4;
    localparam int BYTES  = WORD_W / 8;

    typedef struct packed {
        logic              tpar;
        logic [BYTES-1:0]  bpar;
        logic [TAG_W-1:0]  tag;
        logic [WORD_W-1:0] data;
    } line_t;

    typedef enum logic { ST_IDLE, ST_MEM } st_e;

    function automatic logic [BYTES-1:0] byte_par(input logic [WORD_W-1:0] w);
        logic [BYTES-1:0] p;
        for (int i = 0; i < BYTES; i++) p[i] = ^w[i*8 +: 8];
        return p;
    endfunction

    function automatic logic [WORD_W-1:0] merge_bytes(input logic [WORD_W-1:0] old_w,
                                                      input logic [WORD_W-1:0] new_w,
                                                      input logic [BYTES-1:0]  be);
        logic [WORD_W-1:0] r;
        for (int i = 0; i < BYTES; i++) r[i*8 +: 8] = be[i] ? new_w[i*8 +: 8] : old_w[i*8 +: 8];
        return r;
    endfunction

    function automatic line_t make_line(input logic [TAG_W-1:0] tag,
                                        input logic [WORD_W-1:0] data,
                                        input logic flip);
        line_t l;
        l.tpar = ^tag;
        l.bpar = byte_par(data) ^ {{(BYTES-1){1'b0}}, flip};
        l.tag  = tag;
        l.data = data;
        return l;
    endfunction
endpackage

// File: rtl/wtc_store.sv
module wtc_store
    import wtc_pkg::*;
(
    input  logic             clk,
    input  logic [IDX_W-1:0] rd_idx,
    output line_t            rd_line,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  line_t            wr_line
);
    line_t ram [LINES];

    always_ff @(posedge clk) begin
        if (wr_en) ram[wr_idx] <= wr_line;
    end

    assign rd_line = ram[rd_idx];
endmodule

// File: rtl/wtc_valid.sv
module wtc_valid
    import wtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             inv_req,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    output logic             rd_valid,
    output logic             busy,
    output logic             init
);
    logic             bank;
    logic [IDX_W-1:0] walk;
    logic [1:0]       rdv;

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic bits [LINES];
        logic mine;
        assign mine = (bank == 1'(b));
        always_ff @(posedge clk) begin
            if (set_en && mine) bits[set_idx] <= 1'b1;
            if (busy && (init || !mine)) bits[walk] <= 1'b0;
        end
        assign rdv[b] = bits[rd_idx];
    end

    assign rd_valid = bank ? rdv[1] : rdv[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            bank <= 1'b0;
            busy <= 1'b1;
            init <= 1'b1;
            walk <= '0;
        end else if (busy) begin
            walk <= walk + 1'b1;
            if (&walk) begin
                busy <= 1'b0;
                init <= 1'b0;
            end
        end else if (inv_req) begin
            bank <= ~bank;
            busy <= 1'b1;
            walk <= '0;
        end
    end

    // R8: a clear request during a walk leaves the bank selection alone
    a_r8_refuse_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && inv_req) |=> $stable(bank));
    // R7: the walk ends only after the last index has been cleared
    a_r7_walk_len: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(walk) == {IDX_W{1'b1}}));
    // R9: the power-up clear is always reported as busy
    a_r9_init_busy: assert property (@(posedge clk) disable iff (rst)
        init |-> busy);
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
    import wtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [BYTES-1:0]  cpu_be,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic              cpu_ack,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [BYTES-1:0]  mem_be,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              fault_inj,
    input  line_t             rd_line,
    input  logic              rd_valid,
    input  logic              init,
    output logic              st_wr_en,
    output logic [IDX_W-1:0]  st_wr_idx,
    output line_t             st_wr_line,
    output logic              set_en,
    output logic              par_err,
    output logic [ADDR_W-1:0] err_addr
);
    st_e               st;
    logic [ADDR_W-1:0] q_addr;
    logic              q_we;
    logic [BYTES-1:0]  q_be;
    logic [WORD_W-1:0] q_wdata;
    logic              q_fill;

    logic [TAG_W-1:0]  req_tag;
    logic              io_space, cacheable, tag_ok, par_ok, hit, perr, take;

    assign req_tag   = cpu_addr[ADDR_W-1 -: TAG_W];
    assign io_space  = &cpu_addr[ADDR_W-1 -: IO_W];
    assign cacheable = !io_space && !init;
    assign tag_ok    = cacheable && rd_valid && (rd_line.tag == req_tag);
    assign par_ok    = (rd_line.tpar == ^rd_line.tag) && (rd_line.bpar == byte_par(rd_line.data));
    assign hit       = tag_ok && par_ok;
    assign perr      = tag_ok && !par_ok;
    assign take      = (st == ST_IDLE) && cpu_req;

    assign mem_req   = (st == ST_MEM);
    assign mem_we    = q_we;
    assign mem_be    = q_be;
    assign mem_addr  = q_addr;
    assign mem_wdata = q_wdata;

    always_comb begin
        cpu_ack    = 1'b0;
        cpu_rdata  = rd_line.data;
        st_wr_en   = 1'b0;
        st_wr_idx  = cpu_addr[IDX_W:1];
        st_wr_line = rd_line;
        set_en     = 1'b0;
        if (take && !cpu_we && hit) cpu_ack = 1'b1;
        if (take && cpu_we && hit) begin
            st_wr_en   = 1'b1;
            st_wr_line = make_line(req_tag, merge_bytes(rd_line.data, cpu_wdata, cpu_be), 1'b0);
        end
        if ((st == ST_MEM) && mem_ack) begin
            cpu_ack   = 1'b1;
            cpu_rdata = mem_rdata;
            if (q_fill) begin
                st_wr_en   = 1'b1;
                set_en     = 1'b1;
                st_wr_idx  = q_addr[IDX_W:1];
                st_wr_line = make_line(q_addr[ADDR_W-1 -: TAG_W], mem_rdata, fault_inj);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            q_addr   <= '0;
            q_we     <= 1'b0;
            q_be     <= '0;
            q_wdata  <= '0;
            q_fill   <= 1'b0;
            par_err  <= 1'b0;
            err_addr <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (cpu_req && (cpu_we || !hit)) begin
                        st      <= ST_MEM;
                        q_addr  <= cpu_addr;
                        q_we    <= cpu_we;
                        q_be    <= cpu_be;
                        q_wdata <= cpu_wdata;
                        q_fill  <= !cpu_we && cacheable;
                    end
                    if (cpu_req && perr) begin
                        par_err  <= 1'b1;
                        err_addr <= cpu_addr;
                    end
                end
                ST_MEM: if (mem_ack) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R3: a store accepted in idle becomes a memory write on the next cycle
    a_r3_write_through: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && cpu_req && cpu_we) |=> (mem_req && mem_we));
    // R2: an outstanding memory request keeps its address until acknowledged
    a_r2_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
    // R6: I/O-space requests never complete from the array
    a_r6_no_io_hit: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && cpu_req && io_space) |-> !cpu_ack);
    // R10: the parity error flag stays set once raised
    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        par_err |=> par_err);
endmodule

// File: rtl/wt_word_cache.sv
module wt_word_cache
    import wtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [1:0]        cpu_be,
    input  logic [21:0]       cpu_addr,
    input  logic [15:0]       cpu_wdata,
    output logic              cpu_ack,
    output logic [15:0]       cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [1:0]        mem_be,
    output logic [21:0]       mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [15:0]       mem_rdata,
    input  logic              inv_req,
    output logic              inv_busy,
    input  logic              fault_inj,
    output logic              par_err,
    output logic [21:0]       err_addr
);
    line_t            rd_line, st_wr_line;
    logic             rd_valid, init, st_wr_en, set_en;
    logic [IDX_W-1:0] st_wr_idx;

    wtc_store i_store (
        .clk     (clk),
        .rd_idx  (cpu_addr[IDX_W:1]),
        .rd_line (rd_line),
        .wr_en   (st_wr_en),
        .wr_idx  (st_wr_idx),
        .wr_line (st_wr_line)
    );

    wtc_valid i_valid (
        .clk      (clk),
        .rst      (rst),
        .inv_req  (inv_req),
        .rd_idx   (cpu_addr[IDX_W:1]),
        .set_en   (set_en),
        .set_idx  (st_wr_idx),
        .rd_valid (rd_valid),
        .busy     (inv_busy),
        .init     (init)
    );

    wtc_ctrl i_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_be     (cpu_be),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_ack    (cpu_ack),
        .cpu_rdata  (cpu_rdata),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_be     (mem_be),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .fault_inj  (fault_inj),
        .rd_line    (rd_line),
        .rd_valid   (rd_valid),
        .init       (init),
        .st_wr_en   (st_wr_en),
        .st_wr_idx  (st_wr_idx),
        .st_wr_line (st_wr_line),
        .set_en     (set_en),
        .par_err    (par_err),
        .err_addr   (err_addr)
    );
endmodule

// File: tb/test_wt_word_cache.sv
module test_wt_word_cache;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [1:0]  cpu_be = 2'b00;
    logic [21:0] cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic        cpu_ack;
    logic [15:0] cpu_rdata;
    logic        mem_req, mem_we;
    logic [1:0]  mem_be;
    logic [21:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        inv_req = 1'b0, inv_busy, fault_inj = 1'b0, par_err;
    logic [21:0] err_addr;

    int checks = 0, fails = 0, txns = 0, lat = 0, busy_total = 0;
    logic [21:0] last_addr = '0;
    logic [15:0] shadow [logic [20:0]];

    always #10 clk = ~clk;

    wt_word_cache i_wt_word_cache (.*);

    function automatic logic [15:0] mem_read(input logic [21:0] a);
        if (shadow.exists(a[21:1])) return shadow[a[21:1]];
        return a[16:1] ^ 16'h5A3C;
    endfunction

    // memory model: fixed latency, one acknowledge pulse per request
    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
            lat <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
            lat <= 0;
        end else if (mem_req) begin
            if (lat == 2) begin
                logic [15:0] w;
                w = mem_read(mem_addr);
                mem_rdata <= w;
                if (mem_we) begin
                    if (mem_be[0]) w[7:0]  = mem_wdata[7:0];
                    if (mem_be[1]) w[15:8] = mem_wdata[15:8];
                    shadow[mem_addr[21:1]] = w;
                end
                mem_ack <= 1'b1;
                last_addr <= mem_addr;
                txns <= txns + 1;
            end else lat <= lat + 1;
        end
    end

    always @(negedge clk) if (inv_busy) busy_total <= busy_total + 1;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [1:0] be, input logic [21:0] a,
                          input logic [15:0] wd, output logic [15:0] rd, output int dtx);
        int t0;
        @(negedge clk);
        t0 = txns;
        cpu_req = 1'b1; cpu_we = we; cpu_be = be; cpu_addr = a; cpu_wdata = wd;
        for (int n = 0; n < 50; n++) begin
            #1;
            if (cpu_ack) break;
            @(negedge clk);
        end
        rd = cpu_rdata;
        @(negedge clk);
        cpu_req = 1'b0;
        dtx = txns - t0;
    endtask

    task automatic pulse_inv();
        @(negedge clk); inv_req = 1'b1;
        @(negedge clk); inv_req = 1'b0;
        #1;
    endtask

    typedef struct packed {
        logic        we;
        logic [1:0]  be;
        logic [21:0] addr;
        logic [15:0] wdata;
        logic        exp_mem;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'b11, 22'h001000, 16'h0000, 1'b1, 4'd2},  // R2 read miss
        '{1'b0, 2'b11, 22'h001000, 16'h0000, 1'b0, 4'd1},  // R1 read hit
        '{1'b1, 2'b11, 22'h001000, 16'h1234, 1'b1, 4'd3},  // R3 store through
        '{1'b0, 2'b11, 22'h001000, 16'h0000, 1'b0, 4'd4},  // R4 updated line
        '{1'b1, 2'b10, 22'h001001, 16'hAB00, 1'b1, 4'd4},  // R4 high byte store
        '{1'b0, 2'b11, 22'h001000, 16'h0000, 1'b0, 4'd4},  // R4 merged bytes
        '{1'b0, 2'b11, 22'h003000, 16'h0000, 1'b1, 4'd5},  // R5 conflict fill
        '{1'b0, 2'b11, 22'h001000, 16'h0000, 1'b1, 4'd5},  // R5 evicted
        '{1'b1, 2'b11, 22'h004010, 16'hC0DE, 1'b1, 4'd4},  // R4 store miss
        '{1'b0, 2'b11, 22'h004010, 16'h0000, 1'b1, 4'd4},  // R4 no allocate
        '{1'b0, 2'b11, 22'h004010, 16'h0000, 1'b0, 4'd1},  // R1 now cached
        '{1'b0, 2'b11, 22'h3C0010, 16'h0000, 1'b1, 4'd6},  // R6 io read
        '{1'b0, 2'b11, 22'h3C0010, 16'h0000, 1'b1, 4'd6},  // R6 io read again
        '{1'b1, 2'b11, 22'h3C0010, 16'h7777, 1'b1, 4'd6},  // R6 io store
        '{1'b0, 2'b11, 22'h3C0010, 16'h0000, 1'b1, 4'd6},  // R6 io read back
        '{1'b0, 2'b11, 22'h003FFE, 16'h0000, 1'b1, 4'd1},  // R1 last index miss
        '{1'b0, 2'b11, 22'h003FFE, 16'h0000, 1'b0, 4'd1}   // R1 last index hit
    };

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] rd, exp;
        int dtx, b0;
        repeat (3) @(negedge clk);
        #1;
        check(cpu_ack == 1'b0, "R9 ack in reset", 32'(cpu_ack), 0);
        check(mem_req == 1'b0, "R9 mem_req in reset", 32'(mem_req), 0);
        check(par_err == 1'b0, "R9 par_err in reset", 32'(par_err), 0);
        check(inv_busy == 1'b1, "R9 busy in reset", 32'(inv_busy), 1);
        @(negedge clk); rst = 1'b0;

        // R9: access during the power-up clear bypasses and does not allocate
        access(1'b0, 2'b11, 22'h000100, 16'h0, rd, dtx);
        check(dtx == 1, "R9 init access to memory", 32'(dtx), 1);
        check(inv_busy == 1'b1, "R9 still clearing", 32'(inv_busy), 1);
        for (int n = 0; n < 5000 && inv_busy; n++) @(negedge clk);
        access(1'b0, 2'b11, 22'h000100, 16'h0, rd, dtx);
        check(dtx == 1, "R9 no allocate during init", 32'(dtx), 1);

        for (int i = 0; i < NV; i++) begin
            exp = mem_read(VECS[i].addr);
            access(VECS[i].we, VECS[i].be, VECS[i].addr, VECS[i].wdata, rd, dtx);
            check(dtx == int'(VECS[i].exp_mem), $sformatf("R%0d vec %0d traffic", VECS[i].req, i),
                  32'(dtx), 32'(VECS[i].exp_mem));
            if (!VECS[i].we)
                check(rd == exp, $sformatf("R%0d vec %0d data", VECS[i].req, i), 32'(rd), 32'(exp));
        end
        check(mem_read(22'h001000) == 16'hAB34, "R4 memory bytes", 32'(mem_read(22'h001000)), 32'hAB34);
        check(last_addr == 22'h003FFE, "R2 memory address", 32'(last_addr), 32'h003FFE);

        // R7 / R8: clear, fill during the walk, refused second clear
        access(1'b0, 2'b11, 22'h001000, 16'h0, rd, dtx);
        check(dtx == 0, "R7 cached before clear", 32'(dtx), 0);
        b0 = busy_total;
        pulse_inv();
        check(inv_busy == 1'b1, "R7 busy after clear", 32'(inv_busy), 1);
        access(1'b0, 2'b11, 22'h001000, 16'h0, rd, dtx);
        check(dtx == 1, "R7 miss after clear", 32'(dtx), 1);
        access(1'b0, 2'b11, 22'h001000, 16'h0, rd, dtx);
        check(dtx == 0, "R7 fill survives walk", 32'(dtx), 0);
        pulse_inv();
        access(1'b0, 2'b11, 22'h001000, 16'h0, rd, dtx);
        check(dtx == 0, "R8 clear while busy ignored", 32'(dtx), 0);
        for (int n = 0; n < 5000 && inv_busy; n++) @(negedge clk);
        @(negedge clk);
        check(busy_total - b0 == 4096, "R7 walk length", 32'(busy_total - b0), 4096);
        access(1'b0, 2'b11, 22'h001000, 16'h0, rd, dtx);
        check(dtx == 0, "R8 line kept after walk", 32'(dtx), 0);

        // R10: planted parity fault
        fault_inj = 1'b1;
        access(1'b0, 2'b11, 22'h000200, 16'h0, rd, dtx);
        fault_inj = 1'b0;
        check(par_err == 1'b0, "R10 no error yet", 32'(par_err), 0);
        exp = mem_read(22'h000200);
        access(1'b0, 2'b11, 22'h000200, 16'h0, rd, dtx);
        check(dtx == 1, "R10 refetch on bad parity", 32'(dtx), 1);
        check(rd == exp, "R10 refetched data", 32'(rd), 32'(exp));
        check(par_err == 1'b1, "R10 error flag", 32'(par_err), 1);
        check(err_addr == 22'h000200, "R10 error address", 32'(err_addr), 32'h000200);
        access(1'b0, 2'b11, 22'h000200, 16'h0, rd, dtx);
        check(dtx == 0, "R10 line repaired", 32'(dtx), 0);
        check(par_err == 1'b1, "R10 flag sticky", 32'(par_err), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule